// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that finishes each instruction in exactly one clock cycle. Instruction fetch and data access go through two separate memory ports: a read-only instruction port addressed by the program counter, and a read/write data port. Both memories sit outside the core. Their reads are combinational, and stores are committed by the memory on the rising clock edge. The supported instructions are register-to-register arithmetic and logic, word load, word store, and a conditional branch taken on equal operands.

Within one cycle the core does all of the following. It reads the instruction, decodes the opcode into a small set of strobes and reads two source registers. It computes either a result or an address in the ALU and, when the instruction needs it, accesses data memory. At the clock edge it updates the program counter and writes back one register. The branch compares its two operands with an exclusive-OR in the ALU and tests the result for zero. Debug outputs show the current program counter and the register write that will take effect at the next edge.

Top module: `scpu_core`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the program counter to 0 and clears every general register to zero.
- R2: The program counter is always word aligned. It advances by 4 after every instruction that is not a taken branch.
- R3: An instruction with opcode 000000 writes its result to the register in bits [15:11], using sources from bits [25:21] and [20:16]. Bits [5:0] select the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-on-less-than (result 1 or 0).
- R4: Opcode 100011 (load) reads data memory at source register [25:21] plus the sign-extended immediate in bits [15:0], and writes the returned word to the register in bits [20:16]. The data-read strobe is high during the load.
- R5: Opcode 101011 (store) drives the data write strobe, sets the address to base plus the sign-extended immediate, and sets the write data to the register in bits [20:16]. It writes no register. A later load from the same address returns the stored word.
- R6: Opcode 000100 (branch) with equal operands sets the next PC to PC + 4 + (sign-extended bits [15:0] × 4). Negative offsets are included. The branch writes no register and no memory.
- R7: A branch whose two operands differ falls through to PC + 4.
- R8: Register 0 always reads as zero. A write aimed at it is dropped, and the debug write strobe stays low.
- R9: An unknown opcode, or an opcode-000000 word with an unlisted operation code or nonzero bits [10:6], changes no register and no memory. It advances the PC by 4.
- R10: The data-read strobe is high only for loads and the data-write strobe only for stores, so the two are never high together.
- R11: A register written by one instruction supplies the new value to the instruction in the very next cycle, including as a load result and as a branch operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imemAddr | output | 32 | Instruction fetch byte address (the PC) |
| imemData | input | 32 | Instruction word at imemAddr |
| dmemAddr | output | 32 | Data memory byte address |
| dmemWData | output | 32 | Store data |
| dmemWe | output | 1 | Data memory write strobe |
| dmemRe | output | 1 | Data memory read strobe |
| dmemRData | input | 32 | Data memory read word at dmemAddr |
| dbgPc | output | 32 | Program counter of the instruction now executing |
| dbgRegWe | output | 1 | A register will be written at the next edge |
| dbgRegAddr | output | 5 | Register index being written |
| dbgRegData | output | 32 | Value being written |

## Verification
Two events share one clock edge: the register write-back of one instruction and the operand read of the next. Back-to-back programs provoke this. A load result feeds an add in the following cycle, a loaded base register feeds a store address, and a branch compares a register loaded one cycle earlier. Each step is judged at the debug write port and the data port against values the bench computes from the operands. Branch direction is judged by the PC observed in the following cycle.

// File: rtl/scpu_pkg.sv
package scpu_pkg;
  localparam int XLEN      = 32;
  localparam int REG_NUM   = 32;
  localparam int REG_IDX_W = $clog2(REG_NUM);
  localparam int IMM_W     = 16;

  localparam logic [5:0] OP_ALU   = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_XOR
  } aluOpE;

  // How the ALU operation is chosen for the current instruction
  typedef enum logic [1:0] {
    MODE_ADDR,   // address generation: add
    MODE_CMP,    // branch compare: xor
    MODE_FUNCT,  // taken from the function field
    MODE_NONE
  } aluModeE;

  typedef struct packed {
    logic    regWrite;
    logic    regDst;    // 1: destination from bits [15:11], 0: from [20:16]
    logic    aluSrc;    // 1: second operand is the extended immediate
    logic    memRead;
    logic    memWrite;
    logic    memToReg;  // 1: write back the memory word
    logic    branch;
    aluModeE aluMode;
  } ctrlT;
endpackage

// File: rtl/scpu_control.sv
module scpu_control
  import scpu_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic [4:0] shamt,
  output ctrlT       ctrl,
  output aluOpE      aluOp
);
  logic  fnValid;
  aluOpE fnOp;

  // Secondary decode of the function field
  always_comb begin
    fnValid = (shamt == '0);
    fnOp    = ALU_ADD;
    unique case (funct)
      FN_ADD:  fnOp = ALU_ADD;
      FN_SUB:  fnOp = ALU_SUB;
      FN_AND:  fnOp = ALU_AND;
      FN_OR:   fnOp = ALU_OR;
      FN_SLT:  fnOp = ALU_SLT;
      default: fnValid = 1'b0;
    endcase
  end

  // Primary decode of the opcode
  always_comb begin
    ctrl = '{regWrite: 1'b0, regDst: 1'b0, aluSrc: 1'b0, memRead: 1'b0,
             memWrite: 1'b0, memToReg: 1'b0, branch: 1'b0, aluMode: MODE_NONE};
    unique case (opcode)
      OP_ALU: begin
        ctrl.regWrite = fnValid;
        ctrl.regDst   = 1'b1;
        ctrl.aluMode  = MODE_FUNCT;
      end
      OP_LOAD: begin
        ctrl.regWrite = 1'b1;
        ctrl.aluSrc   = 1'b1;
        ctrl.memRead  = 1'b1;
        ctrl.memToReg = 1'b1;
        ctrl.aluMode  = MODE_ADDR;
      end
      OP_STORE: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memWrite = 1'b1;
        ctrl.aluMode  = MODE_ADDR;
      end
      OP_BEQ: begin
        ctrl.branch  = 1'b1;
        ctrl.aluMode = MODE_CMP;
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (ctrl.aluMode)
      MODE_CMP:   aluOp = ALU_XOR;
      MODE_FUNCT: aluOp = fnOp;
      default:    aluOp = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile #(
  parameter int WIDTH = 32,
  parameter int COUNT = 32,
  localparam int IDX_W = $clog2(COUNT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rdAddrA,
  input  logic [IDX_W-1:0] rdAddrB,
  output logic [WIDTH-1:0] rdDataA,
  output logic [WIDTH-1:0] rdDataB,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic [WIDTH-1:0] wrData
);
  logic [COUNT-1:0][WIDTH-1:0] regBank;

  for (genvar g = 0; g < COUNT; g++) begin : gReg
    if (g == 0) begin : gZero
      assign regBank[g] = '0;
    end else begin : gStore
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                                   q <= '0;
        else if (wrEn && wrAddr == IDX_W'(g))      q <= wrData;
      end
      assign regBank[g] = q;
    end
  end

  assign rdDataA = regBank[rdAddrA];
  assign rdDataB = regBank[rdAddrB];
endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
  import scpu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  aluOpE            op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  always_comb begin
    unique case (op)
      ALU_ADD: result = a + b;
      ALU_SUB: result = a - b;
      ALU_AND: result = a & b;
      ALU_OR:  result = a | b;
      ALU_SLT: result = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_XOR: result = a ^ b;
      default: result = '0;
    endcase
  end

  assign zero = (result == '0);
endmodule

// File: rtl/scpu_datapath.sv
module scpu_datapath
  import scpu_pkg::*;
#(
  parameter int          WIDTH    = XLEN,
  parameter int          COUNT    = REG_NUM,
  parameter logic [31:0] RESET_PC = 32'h0,
  localparam int IDX_W = $clog2(COUNT)
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlT             ctrl,
  input  aluOpE            aluOp,
  input  logic [31:0]      instr,
  output logic [WIDTH-1:0] pc,
  output logic [WIDTH-1:0] dmemAddr,
  output logic [WIDTH-1:0] dmemWData,
  output logic             dmemWe,
  output logic             dmemRe,
  input  logic [WIDTH-1:0] dmemRData,
  output logic             regWeEff,
  output logic [IDX_W-1:0] regWAddr,
  output logic [WIDTH-1:0] regWData
);
  logic [IDX_W-1:0] rsIdx, rtIdx, rdIdx;
  logic [IMM_W-1:0] imm;
  logic [WIDTH-1:0] immExt, branchOff;
  logic [WIDTH-1:0] srcA, srcB, aluB, aluRes;
  logic [WIDTH-1:0] pcPlus4, pcTarget, pcNext;
  logic             aluZero, pcSrc;

  assign rsIdx = instr[25:21];
  assign rtIdx = instr[20:16];
  assign rdIdx = instr[15:11];
  assign imm   = instr[15:0];

  assign immExt    = {{(WIDTH-IMM_W){imm[IMM_W-1]}}, imm};
  assign branchOff = {immExt[WIDTH-3:0], 2'b00};

  scpu_regfile #(.WIDTH(WIDTH), .COUNT(COUNT)) u_regfile (
    .clk     (clk),
    .rst     (rst),
    .rdAddrA (rsIdx),
    .rdAddrB (rtIdx),
    .rdDataA (srcA),
    .rdDataB (srcB),
    .wrEn    (regWeEff),
    .wrAddr  (regWAddr),
    .wrData  (regWData)
  );

  assign aluB = ctrl.aluSrc ? immExt : srcB;

  scpu_alu #(.WIDTH(WIDTH)) u_alu (
    .op     (aluOp),
    .a      (srcA),
    .b      (aluB),
    .result (aluRes),
    .zero   (aluZero)
  );

  // Write-back selection; register 0 is never a real target
  assign regWAddr = ctrl.regDst ? rdIdx : rtIdx;
  assign regWData = ctrl.memToReg ? dmemRData : aluRes;
  assign regWeEff = ctrl.regWrite && (regWAddr != '0);

  assign dmemAddr  = aluRes;
  assign dmemWData = srcB;
  assign dmemWe    = ctrl.memWrite;
  assign dmemRe    = ctrl.memRead;

  // Next-PC selection
  assign pcPlus4  = pc + WIDTH'(4);
  assign pcTarget = pcPlus4 + branchOff;
  assign pcSrc    = ctrl.branch && aluZero;
  assign pcNext   = pcSrc ? pcTarget : pcPlus4;

  always_ff @(posedge clk) begin
    if (rst) pc <= WIDTH'(RESET_PC);
    else     pc <= pcNext;
  end
endmodule

// File: rtl/scpu_core.sv
module scpu_core
  import scpu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imemAddr,
  input  logic [31:0] imemData,
  output logic [31:0] dmemAddr,
  output logic [31:0] dmemWData,
  output logic        dmemWe,
  output logic        dmemRe,
  input  logic [31:0] dmemRData,
  output logic [31:0] dbgPc,
  output logic        dbgRegWe,
  output logic [4:0]  dbgRegAddr,
  output logic [31:0] dbgRegData
);
  ctrlT        ctrl;
  aluOpE       aluOp;
  logic [31:0] pc;

  scpu_control u_control (
    .opcode (imemData[31:26]),
    .funct  (imemData[5:0]),
    .shamt  (imemData[10:6]),
    .ctrl   (ctrl),
    .aluOp  (aluOp)
  );

  scpu_datapath #(.WIDTH(XLEN), .COUNT(REG_NUM)) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .aluOp     (aluOp),
    .instr     (imemData),
    .pc        (pc),
    .dmemAddr  (dmemAddr),
    .dmemWData (dmemWData),
    .dmemWe    (dmemWe),
    .dmemRe    (dmemRe),
    .dmemRData (dmemRData),
    .regWeEff  (dbgRegWe),
    .regWAddr  (dbgRegAddr),
    .regWData  (dbgRegData)
  );

  assign imemAddr = pc;
  assign dbgPc    = pc;
endmodule

// File: rtl/scpu_core_checker.sv
module scpu_core_checker
  import scpu_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [5:0]  imemOp,
  input logic [31:0] dbgPc,
  input logic        dmemWe,
  input logic        dmemRe,
  input logic        dbgRegWe,
  input logic [4:0]  dbgRegAddr
);
  logic knownOp;
  assign knownOp = (imemOp == OP_ALU) || (imemOp == OP_LOAD) ||
                   (imemOp == OP_STORE) || (imemOp == OP_BEQ);

  AST_RESET_PC: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dbgPc == 32'h0)); // R1

  AST_PC_SEQ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(imemOp) != OP_BEQ) |-> (dbgPc == $past(dbgPc) + 32'd4)); // R2

  AST_PC_ALIGN: assert property (@(posedge clk) disable iff (rst)
    dbgPc[1:0] == 2'b00); // R2

  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    dmemWe |-> !dbgRegWe); // R5

  AST_BEQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (imemOp == OP_BEQ) |-> (!dmemWe && !dbgRegWe)); // R6

  AST_R0_SILENT: assert property (@(posedge clk) disable iff (rst)
    dbgRegWe |-> (dbgRegAddr != 5'd0)); // R8

  AST_UNKNOWN_INERT: assert property (@(posedge clk) disable iff (rst)
    !knownOp |-> (!dbgRegWe && !dmemWe && !dmemRe)); // R9

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(dmemRe && dmemWe)); // R10
endmodule

bind scpu_core scpu_core_checker u_checker (
  .clk        (clk),
  .rst        (rst),
  .imemOp     (imemData[31:26]),
  .dbgPc      (dbgPc),
  .dmemWe     (dmemWe),
  .dmemRe     (dmemRe),
  .dbgRegWe   (dbgRegWe),
  .dbgRegAddr (dbgRegAddr)
);

// File: tb/test_scpu_core.sv
`timescale 1ns/1ps
module test_scpu_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWData, dmemRData;
  logic        dmemWe, dmemRe, dbgRegWe;
  logic [31:0] dbgPc, dbgRegData;
  logic [4:0]  dbgRegAddr;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int checks = 0;
  int errors = 0;

  localparam logic [5:0] OPC_LW = 6'b100011, OPC_SW = 6'b101011, OPC_BEQ = 6'b000100;

  always #2.5 clk = ~clk;

  assign imemData  = imem[imemAddr[7:2]];
  assign dmemRData = dmem[dmemAddr[7:2]];
  always @(posedge clk) if (dmemWe) dmem[dmemAddr[7:2]] = dmemWData;

  scpu_core i_scpu_core (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWData(dmemWData), .dmemWe(dmemWe), .dmemRe(dmemRe),
    .dmemRData(dmemRData), .dbgPc(dbgPc), .dbgRegWe(dbgRegWe),
    .dbgRegAddr(dbgRegAddr), .dbgRegData(dbgRegData)
  );

  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic stepWrite(string req, int pcExp, int addr, logic [31:0] data);
    check(req, "pc", dbgPc, 32'(pcExp));
    check(req, "regWe", 32'(dbgRegWe), 32'd1);
    check(req, "regAddr", 32'(dbgRegAddr), 32'(addr));
    check(req, "regData", dbgRegData, data);
    @(negedge clk);
  endtask

  task automatic stepQuiet(string req, int pcExp);
    check(req, "pc", dbgPc, 32'(pcExp));
    check(req, "regWe", 32'(dbgRegWe), 32'd0);
    check(req, "memWe", 32'(dmemWe), 32'd0);
    @(negedge clk);
  endtask

  task automatic testAluLoad();
    logic [31:0] a, b;
    a = 32'h12345678;
    b = 32'hF0F00FF0;
    clearMem();
    dmem[0] = a;
    dmem[1] = b;
    imem[0] = encI(OPC_LW, 0, 1, 0);
    imem[1] = encI(OPC_LW, 0, 2, 4);
    imem[2] = encR(1, 2, 3, 6'h20);
    imem[3] = encR(1, 2, 4, 6'h22);
    imem[4] = encR(1, 2, 5, 6'h24);
    imem[5] = encR(1, 2, 6, 6'h25);
    imem[6] = encR(1, 2, 7, 6'h2A);
    imem[7] = encR(2, 1, 8, 6'h2A);
    imem[8] = encR(1, 2, 9, 6'h27);
    doReset();
    check("R1", "pc after reset", dbgPc, 32'h0);
    check("R4", "load read strobe", 32'(dmemRe), 32'd1);
    check("R4", "load address", dmemAddr, 32'h0);
    stepWrite("R4", 0, 1, a);
    stepWrite("R4", 4, 2, b);
    stepWrite("R11 R3 add", 8, 3, a + b);
    stepWrite("R3 sub", 12, 4, a - b);
    stepWrite("R3 and", 16, 5, a & b);
    stepWrite("R3 or", 20, 6, a | b);
    stepWrite("R3 slt pos<neg", 24, 7, 32'd0);
    stepWrite("R3 slt neg<pos", 28, 8, 32'd1);
    check("R10", "read strobe off", 32'(dmemRe), 32'd0);
    stepQuiet("R9 unlisted funct", 32);
    check("R2", "pc advance", dbgPc, 32'd36);
  endtask

  task automatic testStore();
    clearMem();
    dmem[0] = 32'hCAFEF00D;
    dmem[3] = 32'h20;
    imem[0] = encI(OPC_LW, 0, 1, 0);
    imem[1] = encI(OPC_LW, 0, 9, 12);
    imem[2] = encI(OPC_SW, 9, 1, -4);
    imem[3] = encI(OPC_LW, 9, 10, -4);
    doReset();
    stepWrite("R4", 0, 1, 32'hCAFEF00D);
    stepWrite("R4", 4, 9, 32'h20);
    check("R5", "store strobe", 32'(dmemWe), 32'd1);
    check("R11 R5", "store address", dmemAddr, 32'h1C);
    check("R5", "store data", dmemWData, 32'hCAFEF00D);
    check("R10", "no read on store", 32'(dmemRe), 32'd0);
    check("R5", "no reg write", 32'(dbgRegWe), 32'd0);
    check("R5", "pc", dbgPc, 32'd8);
    @(negedge clk);
    stepWrite("R5 R4 readback", 12, 10, 32'hCAFEF00D);
  endtask

  task automatic testBranch();
    clearMem();
    dmem[0] = 32'd5;
    dmem[1] = 32'd9;
    dmem[2] = 32'd5;
    imem[0] = encI(OPC_LW, 0, 1, 0);
    imem[1] = encI(OPC_LW, 0, 2, 4);
    imem[2] = encI(OPC_LW, 0, 3, 8);
    imem[3] = encI(OPC_BEQ, 1, 3, 2);
    imem[4] = encR(1, 2, 4, 6'h20);
    imem[5] = encR(1, 2, 5, 6'h22);
    imem[6] = encI(OPC_BEQ, 1, 2, 5);
    imem[7] = encI(OPC_BEQ, 0, 0, -4);
    doReset();
    stepWrite("R4", 0, 1, 32'd5);
    stepWrite("R4", 4, 2, 32'd9);
    stepWrite("R4", 8, 3, 32'd5);
    stepQuiet("R11 R6 beq equal", 12);
    stepQuiet("R6 taken target", 24);
    stepQuiet("R7 not taken", 28);
    stepWrite("R6 backward target", 16, 4, 32'd14);
  endtask

  task automatic testZeroAndUnknown();
    clearMem();
    dmem[0] = 32'hDEADBEEF;
    imem[0] = encI(OPC_LW, 0, 1, 0);
    imem[1] = encI(OPC_LW, 0, 0, 0);
    imem[2] = encR(1, 1, 0, 6'h20);
    imem[3] = encR(0, 0, 5, 6'h25);
    imem[4] = 32'hFC00_0000;
    imem[5] = encR(1, 1, 6, 6'h20) | 32'h0000_0040;
    imem[6] = encR(1, 1, 7, 6'h25);
    doReset();
    stepWrite("R4", 0, 1, 32'hDEADBEEF);
    stepQuiet("R8 load to r0", 4);
    stepQuiet("R8 alu to r0", 8);
    stepWrite("R8 r0 reads zero", 12, 5, 32'h0);
    check("R10", "no read unknown", 32'(dmemRe), 32'd0);
    stepQuiet("R9 unknown opcode", 16);
    stepQuiet("R9 nonzero shift field", 20);
    stepWrite("R9 state intact", 24, 7, 32'hDEADBEEF);
  endtask

  task automatic testMidReset();
    clearMem();
    dmem[0] = 32'h77;
    imem[0] = encI(OPC_LW, 0, 1, 0);
    imem[1] = encI(OPC_LW, 0, 2, 0);
    imem[2] = 32'h0;
    imem[3] = 32'h0;
    doReset();
    stepWrite("R4", 0, 1, 32'h77);
    stepWrite("R4", 4, 2, 32'h77);
    @(negedge clk);
    imem[0] = encR(1, 2, 3, 6'h25);
    doReset();
    check("R1", "pc after mid-run reset", dbgPc, 32'h0);
    check("R1", "registers cleared", dbgRegData, 32'h0);
    check("R1", "write target", 32'(dbgRegAddr), 32'd3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clearMem();
    testAluLoad();
    testStore();
    testBranch();
    testZeroAndUnknown();
    testMidReset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule